// File: doc/BRIEF.md
# Bit Access Read-Modify-Write Unit

This block gives a processor core single-bit access to the bit-addressable parts of a small microcontroller memory map. The core presents an 8-bit bit address with an operand kind: a plain bit, a complemented bit, or the carry flag. It can also present a write strobe with a one-bit write value. The block works out which byte holds the bit and which bit of that byte is meant. It reads the byte through a combinational byte-read port and returns the selected bit one cycle later.

For a write, the block captures the containing byte and replaces the one addressed bit. In the following cycle it writes the whole byte back through a byte-write port that serves both internal RAM and the special function registers. The two general-purpose I/O port bytes get special treatment. A read-modify-write takes its source byte from the port output latch, not from the pins. A plain read of a port bit takes the pins or the latch, as the `pinSel` input chooses. The byte storage, the port latches and pin sampling all live outside the block. The latch and pin values arrive as inputs, and a write-back to a port byte address is what updates that port's latch.

Top module: `bitacc_unit`

## Requirements
- R1: When `reqAddr[7]` is 0, the containing byte is at RAM address 0x20 + `reqAddr[6:3]` and the bit index is `reqAddr[2:0]`. This holds for both reads and write-backs.
- R2: When `reqAddr[7]` is 1, the containing byte is the register at {1, `reqAddr[6:3]`, 000} and the bit index is `reqAddr[2:0]`.
- R3: With `reqKind` = 2'b01 (complemented), `rdBit` is the inverse of the addressed bit. The write strobe has no effect: no byte write occurs and `busy` stays low.
- R4: With `reqKind` = 2'b10 (carry), the operand is bit 7 of the status byte at 0xD0 and `reqAddr` is ignored. A carry write writes back the status byte with only bit 7 changed.
- R5: An accepted write captures the containing byte. In the next cycle `busy` and `memWrEn` are high for exactly one cycle, and `memWrData` equals the captured byte with only the indexed bit replaced by `reqWrData`. After reset `busy`, `memWrEn`, `rdValid` and `errFlag` are 0.
- R6: For the port bytes at 0x90 and 0xB0, a write takes its source byte from `portALatch` or `portBLatch` (never from the pins, whatever `pinSel` is) and writes the modified byte to that port's address.
- R7: A read that does not write back takes a port bit from the pins when `pinSel` = 1 and from the latch when `pinSel` = 0. Other bytes come from `memRdData`.
- R8: A bit address in the register half whose byte is not implemented (rows 0x80, 0xA0, 0xC0, 0xD8, 0xE8, 0xF8) returns `rdBit` = 0 and raises `errFlag` with the response, and no write-back occurs.
- R9: A request presented while `busy` is high is ignored. It produces no response and no write.
- R10: Every accepted request produces `rdValid` high in the cycle after acceptance, with `rdBit` and `errFlag` valid in that cycle. Reads can be accepted in back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | 8 | Bit address |
| reqKind | input | 2 | 00 plain, 01 complemented, 10 carry (11 acts as plain) |
| reqWrite | input | 1 | Write strobe |
| reqWrData | input | 1 | Bit value to write |
| pinSel | input | 1 | Read port bits from pins (1) or latch (0) |
| memRdAddr | output | 8 | Byte read address, combinational from the request |
| memRdData | input | 8 | Byte read data for `memRdAddr` |
| memWrEn | output | 1 | Byte write strobe |
| memWrAddr | output | 8 | Byte write address |
| memWrData | output | 8 | Byte write data |
| portAPins | input | 8 | Pin values of the port byte at 0x90 |
| portALatch | input | 8 | Output latch of the port byte at 0x90 |
| portBPins | input | 8 | Pin values of the port byte at 0xB0 |
| portBLatch | input | 8 | Output latch of the port byte at 0xB0 |
| rdValid | output | 1 | Response valid |
| rdBit | output | 1 | Returned bit |
| errFlag | output | 1 | Response addressed an unimplemented register |
| busy | output | 1 | Write phase in progress; requests ignored |

## Verification
The write phase of one request can coincide with a new request arriving at the inputs. The bench provokes this by holding a second write request during the busy cycle. It then judges that no response, no second byte write and no further busy cycle follow. A second overlap is a port write-back in the same cycle as a source choice between latch and pin. Here the bench sets the pins and the latch to different patterns, writes with `pinSel` high, and expects the data to be built from the latch. Later pin and latch reads must then see the updated latch.

// File: rtl/bitacc_pkg.sv
package bitacc_pkg;

  localparam int BYTE_W = 8;
  localparam int IDX_W  = $clog2(BYTE_W);
  localparam int ROW_W  = BYTE_W - 1 - IDX_W;

  typedef enum logic [1:0] {
    KIND_PLAIN = 2'b00,
    KIND_INV   = 2'b01,
    KIND_CARRY = 2'b10
  } opKindE;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_WRPH  = 1'b1
  } phaseE;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic issueWrite;
  } dpStrobeT;

endpackage

// File: rtl/bitacc_ctrl.sv
module bitacc_ctrl
  import bitacc_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     reqWrite,
  input  logic [1:0] reqKind,
  input  logic     mapErr,
  output dpStrobeT strobe,
  output logic     busy
);

  phaseE phase;
  phaseE phaseNext;
  logic  accept;
  logic  wantWrite;

  // a complemented operand never writes; a bad map never writes
  assign accept    = reqValid && (phase == ST_IDLE);
  assign wantWrite = reqWrite && (opKindE'(reqKind) != KIND_INV) && !mapErr;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      ST_IDLE: if (accept && wantWrite) phaseNext = ST_WRPH;
      ST_WRPH: phaseNext = ST_IDLE;
      default: phaseNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= ST_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    strobe            = '0;
    strobe.capture    = accept;
    strobe.issueWrite = (phase == ST_WRPH);
  end

  assign busy = (phase == ST_WRPH);

endmodule

// File: rtl/bitacc_dp.sv
module bitacc_dp
  import bitacc_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RAM_BIT_BASE = 8'h20,
  parameter logic [BYTE_W-1:0] STATUS_ADDR  = 8'hD0,
  parameter int                CARRY_IDX    = 7,
  parameter logic [BYTE_W-1:0] PORT_A_ADDR  = 8'h90,
  parameter logic [BYTE_W-1:0] PORT_B_ADDR  = 8'hB0,
  parameter logic [(1<<ROW_W)-1:0] SFR_ROW_MASK = 16'h56EE
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          strobe,
  input  logic [BYTE_W-1:0] reqAddr,
  input  logic [1:0]        reqKind,
  input  logic              reqWrite,
  input  logic              reqWrData,
  input  logic              pinSel,
  input  logic [BYTE_W-1:0] memRdData,
  input  logic [BYTE_W-1:0] portAPins,
  input  logic [BYTE_W-1:0] portALatch,
  input  logic [BYTE_W-1:0] portBPins,
  input  logic [BYTE_W-1:0] portBLatch,
  output logic [BYTE_W-1:0] memRdAddr,
  output logic              mapErr,
  output logic              rdValid,
  output logic              rdBit,
  output logic              errFlag,
  output logic              memWrEn,
  output logic [BYTE_W-1:0] memWrAddr,
  output logic [BYTE_W-1:0] memWrData
);

  localparam logic [IDX_W-1:0] CARRY_BIT = IDX_W'(CARRY_IDX);

  opKindE            kind;
  logic              sfrHalf;
  logic [ROW_W-1:0]  row;
  logic [BYTE_W-1:0] byteAddr;
  logic [IDX_W-1:0]  bitIdx;
  logic              writeIntent;
  logic              hitA;
  logic              hitB;
  logic [BYTE_W-1:0] srcByte;
  logic [BYTE_W-1:0] newByte;
  logic              selBit;
  logic              outBit;

  assign kind    = opKindE'(reqKind);
  assign sfrHalf = reqAddr[BYTE_W-1];
  assign row     = reqAddr[BYTE_W-2:IDX_W];

  // bit address to containing byte and bit index
  always_comb begin
    if (kind == KIND_CARRY) begin
      byteAddr = STATUS_ADDR;
      bitIdx   = CARRY_BIT;
    end else if (sfrHalf) begin
      byteAddr = {1'b1, row, {IDX_W{1'b0}}};
      bitIdx   = reqAddr[IDX_W-1:0];
    end else begin
      byteAddr = RAM_BIT_BASE + BYTE_W'(row);
      bitIdx   = reqAddr[IDX_W-1:0];
    end
  end

  assign mapErr      = (kind != KIND_CARRY) && sfrHalf && !SFR_ROW_MASK[row];
  assign memRdAddr   = byteAddr;
  assign writeIntent = reqWrite && (kind != KIND_INV);

  // port bytes: modify from latch, plain read from pins or latch
  assign hitA = (byteAddr == PORT_A_ADDR);
  assign hitB = (byteAddr == PORT_B_ADDR);

  always_comb begin
    if (hitA)      srcByte = (pinSel && !writeIntent) ? portAPins : portALatch;
    else if (hitB) srcByte = (pinSel && !writeIntent) ? portBPins : portBLatch;
    else           srcByte = memRdData;
  end

  // single-bit insertion
  for (genvar g = 0; g < BYTE_W; g++) begin : g_insert
    assign newByte[g] = (bitIdx == IDX_W'(g)) ? reqWrData : srcByte[g];
  end

  assign selBit = srcByte[bitIdx];
  assign outBit = mapErr ? 1'b0 : ((kind == KIND_INV) ? ~selBit : selBit);

  logic              rdValidQ;
  logic              rdBitQ;
  logic              errQ;
  logic [BYTE_W-1:0] wrAddrQ;
  logic [BYTE_W-1:0] wrByteQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValidQ <= 1'b0;
      rdBitQ   <= 1'b0;
      errQ     <= 1'b0;
      wrAddrQ  <= '0;
      wrByteQ  <= '0;
    end else begin
      rdValidQ <= strobe.capture;
      if (strobe.capture) begin
        rdBitQ  <= outBit;
        errQ    <= mapErr;
        wrAddrQ <= byteAddr;
        wrByteQ <= newByte;
      end
    end
  end

  assign rdValid   = rdValidQ;
  assign rdBit     = rdBitQ;
  assign errFlag   = rdValidQ && errQ;
  assign memWrEn   = strobe.issueWrite;
  assign memWrAddr = wrAddrQ;
  assign memWrData = wrByteQ;

endmodule

// File: rtl/bitacc_unit.sv
module bitacc_unit
  import bitacc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [7:0]  reqAddr,
  input  logic [1:0]  reqKind,
  input  logic        reqWrite,
  input  logic        reqWrData,
  input  logic        pinSel,
  output logic [7:0]  memRdAddr,
  input  logic [7:0]  memRdData,
  output logic        memWrEn,
  output logic [7:0]  memWrAddr,
  output logic [7:0]  memWrData,
  input  logic [7:0]  portAPins,
  input  logic [7:0]  portALatch,
  input  logic [7:0]  portBPins,
  input  logic [7:0]  portBLatch,
  output logic        rdValid,
  output logic        rdBit,
  output logic        errFlag,
  output logic        busy
);

  dpStrobeT strobe;
  logic     mapErr;

  bitacc_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqKind  (reqKind),
    .mapErr   (mapErr),
    .strobe   (strobe),
    .busy     (busy)
  );

  bitacc_dp dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .reqKind    (reqKind),
    .reqWrite   (reqWrite),
    .reqWrData  (reqWrData),
    .pinSel     (pinSel),
    .memRdData  (memRdData),
    .portAPins  (portAPins),
    .portALatch (portALatch),
    .portBPins  (portBPins),
    .portBLatch (portBLatch),
    .memRdAddr  (memRdAddr),
    .mapErr     (mapErr),
    .rdValid    (rdValid),
    .rdBit      (rdBit),
    .errFlag    (errFlag),
    .memWrEn    (memWrEn),
    .memWrAddr  (memWrAddr),
    .memWrData  (memWrData)
  );

endmodule

// File: rtl/bitacc_chk.sv
module bitacc_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rdValid,
  input logic       rdBit,
  input logic       errFlag,
  input logic       busy,
  input logic       memWrEn,
  input logic [7:0] memWrAddr
);

  assert_busy_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  assert_write_has_response_R5: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> rdValid);

  assert_ignore_while_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !rdValid);

  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (!rdBit && !memWrEn));

  assert_write_target_R1: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (memWrAddr[7] || (memWrAddr[7:4] == 4'h2)));

  assert_err_needs_valid_R10: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> rdValid);

endmodule

bind bitacc_unit bitacc_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .rdValid   (rdValid),
  .rdBit     (rdBit),
  .errFlag   (errFlag),
  .busy      (busy),
  .memWrEn   (memWrEn),
  .memWrAddr (memWrAddr)
);

// File: tb/bitacc_unit_tb.sv
`timescale 1ns/1ps
module bitacc_unit_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [7:0] reqAddr = '0;
  logic [1:0] reqKind = '0;
  logic       reqWrite = 1'b0;
  logic       reqWrData = 1'b0;
  logic       pinSel = 1'b0;
  logic [7:0] memRdAddr;
  logic [7:0] memRdData;
  logic       memWrEn;
  logic [7:0] memWrAddr;
  logic [7:0] memWrData;
  logic [7:0] portAPins = 8'hC3;
  logic [7:0] portALatch;
  logic [7:0] portBPins = 8'h96;
  logic [7:0] portBLatch;
  logic       rdValid;
  logic       rdBit;
  logic       errFlag;
  logic       busy;

  logic [7:0] mem [256];
  int errors = 0;
  int total  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bitacc_unit dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqKind(reqKind), .reqWrite(reqWrite), .reqWrData(reqWrData),
    .pinSel(pinSel), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .portAPins(portAPins), .portALatch(portALatch),
    .portBPins(portBPins), .portBLatch(portBLatch),
    .rdValid(rdValid), .rdBit(rdBit), .errFlag(errFlag), .busy(busy)
  );

  // storage and port latch model
  assign memRdData = mem[memRdAddr];
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portALatch <= 8'h5A;
      portBLatch <= 8'h3C;
    end else if (memWrEn) begin
      mem[memWrAddr] <= memWrData;
      if (memWrAddr == 8'h90) portALatch <= memWrData;
      if (memWrAddr == 8'hB0) portBLatch <= memWrData;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] eAddr(input logic [7:0] a, input logic [1:0] k);
    if (k == 2'b10) return 8'hD0;
    if (a[7]) return {1'b1, a[6:3], 3'b000};
    return 8'h20 + {4'h0, a[6:3]};
  endfunction

  function automatic logic eErr(input logic [7:0] a, input logic [1:0] k);
    logic [3:0] r;
    r = a[6:3];
    if (k == 2'b10 || !a[7]) return 1'b0;
    return (r == 0) || (r == 4) || (r == 8) || (r == 11) || (r == 13) || (r == 15);
  endfunction

  function automatic string tagOf(input logic [7:0] a, input logic [1:0] k, input logic wi);
    logic [7:0] ba;
    ba = eAddr(a, k);
    if (eErr(a, k)) return "R8";
    if (k == 2'b10) return "R4";
    if (k == 2'b01) return "R3";
    if (ba == 8'h90 || ba == 8'hB0) return wi ? "R6" : "R7";
    return a[7] ? "R2" : "R1";
  endfunction

  task automatic runReq(input logic [7:0] a, input logic [1:0] k, input logic wr,
                        input logic wd, input logic ps);
    logic [7:0] ba, src, nb;
    logic [2:0] ix;
    logic er, wi, eb, ewr;
    string tag;
    @(negedge clk);
    ba = eAddr(a, k);
    ix = (k == 2'b10) ? 3'd7 : a[2:0];
    er = eErr(a, k);
    wi = wr && (k != 2'b01);
    tag = tagOf(a, k, wi);
    if (ba == 8'h90)      src = (ps && !wi) ? portAPins : portALatch;
    else if (ba == 8'hB0) src = (ps && !wi) ? portBPins : portBLatch;
    else                  src = mem[ba];
    eb  = er ? 1'b0 : ((k == 2'b01) ? ~src[ix] : src[ix]);
    nb  = src;
    nb[ix] = wd;
    ewr = wi && !er;
    reqValid = 1'b1; reqAddr = a; reqKind = k; reqWrite = wr; reqWrData = wd; pinSel = ps;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    chk("R10", "rdValid", rdValid, 1);
    chk(tag, "rdBit", rdBit, eb);
    chk(tag, "errFlag", errFlag, er);
    chk(tag, "busy", busy, ewr);
    chk(tag, "memWrEn", memWrEn, ewr);
    if (ewr) begin
      chk(tag, "memWrAddr", memWrAddr, ba);
      chk(tag, "memWrData", memWrData, nb);
      @(negedge clk);
      chk("R5", "busy after write", busy, 0);
      chk("R5", "memWrEn after write", memWrEn, 0);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, total);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 2));
    mem[8'hD0] = 8'h3C;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R5", "reset busy", busy, 0);
    chk("R5", "reset memWrEn", memWrEn, 0);
    chk("R10", "reset rdValid", rdValid, 0);
    chk("R8", "reset errFlag", errFlag, 0);

    // plain reads, latch then pins
    for (int a = 0; a < 256; a++) runReq(8'(a), 2'b00, 1'b0, 1'b0, 1'b0);
    for (int a = 0; a < 256; a++) runReq(8'(a), 2'b00, 1'b0, 1'b0, 1'b1);
    // complemented reads, and complemented with write strobe (R3 no write)
    for (int a = 0; a < 256; a++) runReq(8'(a), 2'b01, a[0], 1'b1, 1'b0);
    // carry read and write (R4)
    runReq(8'h00, 2'b10, 1'b0, 1'b0, 1'b0);
    runReq(8'h5B, 2'b10, 1'b1, 1'b1, 1'b0);
    runReq(8'hD7, 2'b00, 1'b0, 1'b0, 1'b0);
    chk("R4", "status byte after carry write", mem[8'hD0], 8'hBC);
    runReq(8'hFF, 2'b10, 1'b1, 1'b0, 1'b1);
    chk("R4", "status byte after carry clear", mem[8'hD0], 8'h3C);
    // write sweep, pinSel high so port writes must still use latch (R6)
    for (int a = 0; a < 256; a++) runReq(8'(a), 2'b00, 1'b1, ~mem[eAddr(8'(a), 2'b00)][a % 8], 1'b1);
    // latch now holds the modified bytes; read back from latch and from pins (R7)
    for (int a = 8'h90; a < 8'h98; a++) runReq(8'(a), 2'b00, 1'b0, 1'b0, 1'b0);
    for (int a = 8'hB0; a < 8'hB8; a++) runReq(8'(a), 2'b00, 1'b0, 1'b0, 1'b1);

    // R9: request during the busy cycle is ignored
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 8'h05; reqKind = 2'b00; reqWrite = 1'b1; reqWrData = 1'b1; pinSel = 1'b0;
    @(negedge clk);
    chk("R9", "first busy", busy, 1);
    reqAddr = 8'h0A; reqWrData = 1'b0;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
    chk("R9", "no response to busy request", rdValid, 0);
    chk("R9", "no second busy", busy, 0);
    chk("R9", "no second write", memWrEn, 0);
    @(negedge clk);
    chk("R9", "still quiet", memWrEn, 0);

    // R10: back-to-back reads
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 8'h10; reqKind = 2'b00; reqWrite = 1'b0;
    @(negedge clk);
    chk("R10", "first of pair", rdValid, 1);
    chk("R10", "first bit", rdBit, mem[8'h22][0]);
    reqAddr = 8'h11;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R10", "second of pair", rdValid, 1);
    chk("R10", "second bit", rdBit, mem[8'h22][1]);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; total++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

endmodule